// File: doc/BRIEF.md
# Pointer-Indexed Address Generation Unit

This unit turns a 9-bit source-operand field into the memory address of a load or store. It keeps two 20-bit pointer registers, A and B. When the field is a pointer expression, the unit forms the address from the selected pointer. It does this in one of two ways. It can add a signed index and leave the pointer untouched. Or it can step the pointer, either before the address is formed (pre-update) or after it (post-update).

The index or step is scaled by the access size. The pointer writeback is committed on the clock edge of the access strobe. When the operand is not a pointer expression, the address is passed straight through from a register-value input.

Software sets either pointer through a dedicated load port. That port takes priority over an update of the same pointer in the same cycle. All address and pointer arithmetic wraps modulo 2^20. The address and the selected-pointer output are combinational from the inputs and the current pointer values. The pointers change only at a clock edge.

Top module: `ptr_agu`

## Requirements
- R1: Reset (rst_n low) clears both pointers to zero, and they read back as zero on ptr_a_o and ptr_b_o.
- R2: The operand is a pointer expression only when is_ptr_i is 1 and field bit 8 is 1. Field bit 7 then selects the pointer (0 = A, 1 = B), and sel_o reports that choice.
- R3: When field bit 6 is 0 (no update), addr_o equals the pointer plus the scaled two's-complement value of bits 5:0 (-32..+31). The pointer does not change, even with commit_i high. For example, low byte 0x01 gives +1, 0x3F gives -1, 0x20 gives -32, and 0x00 and 0x80 give the plain pointers A and B.
- R4: An index from -16..+15 encoded with bit 5 equal to bit 4 gives the same address as the value of bits 4:0 read as a 5-bit signed number.
- R5: When bit 6 is 1 and bit 5 is 0 (pre-update), addr_o equals the pointer plus the scaled step, and commit_i writes that same value into the pointer. For example, 0x41 steps by +1, 0x5F by -1 and 0x50 by -16.
- R6: When bit 6 is 1 and bit 5 is 1 (post-update), addr_o equals the current pointer, and commit_i writes the pointer plus the scaled step. For example, 0x61 steps by +1, 0x7F by -1, 0x60 by +16, and 0xFF is a post-decrement of B.
- R7: In update mode, bits 4:0 are a signed step. The code 00000 means +16.
- R8: size_i scales the index or step: 0 = byte (×1), 1 = word (×2), 2 = long (×4), 3 = long (×4).
- R9: All address and pointer sums wrap modulo 2^20.
- R10: When commit_i is 0 and ld_en_i is 0, neither pointer changes.
- R11: When ld_en_i is 1, ld_val_i is written to the pointer chosen by ld_sel_i (0 = A, 1 = B) at the next edge. It wins over a committed update of the same pointer, and the other pointer still takes its update.
- R12: When the operand is not a pointer expression, addr_o equals reg_val_i and sel_o is 0. Neither pointer changes on commit_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| field_i | input | 9 | Source-operand field |
| is_ptr_i | input | 1 | Marks the field as a possible pointer expression |
| size_i | input | 2 | Access size: 0 byte, 1 word, 2 or 3 long |
| commit_i | input | 1 | Access strobe; commits the pointer update |
| reg_val_i | input | 20 | Address used for non-pointer operands |
| ld_en_i | input | 1 | Software pointer load enable |
| ld_sel_i | input | 1 | Pointer to load: 0 A, 1 B |
| ld_val_i | input | 20 | Value to load |
| addr_o | output | 20 | Effective address |
| sel_o | output | 1 | Pointer selected by the field |
| ptr_a_o | output | 20 | Registered pointer A |
| ptr_b_o | output | 20 | Registered pointer B |

## Verification
The hardest case to reach is a committed update and a software load landing in the same cycle. It matters most when both target the same pointer, because the load must win, and when they target different pointers, because both must take effect. The random stimulus biases the load select toward the field's pointer bit and raises the load rate so that collisions are frequent. Directed cycles also force both variants. Separate directed cycles load pointers near 0 and near 2^20 and apply long-sized negative and +16 steps, which pushes the sums across the wrap boundary.

// File: rtl/agu_pkg.sv
package agu_pkg;

  localparam int FIELD_W = 9;
  localparam int OFF_W   = 7;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LALT = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic                    valid;
    logic                    sel;
    logic                    upd;
    logic                    post;
    logic signed [OFF_W-1:0] off;
  } ptr_op_t;

endpackage

// File: rtl/ptr_field_decode.sv
module ptr_field_decode
  import agu_pkg::*;
(
  input  logic [FIELD_W-1:0] field_i,
  input  logic               is_ptr_i,
  output ptr_op_t            op_o
);

  logic signed [OFF_W-1:0] idx_off;
  logic signed [OFF_W-1:0] step_off;

  always_comb begin
    // Non-modifying: 6-bit signed index, sign-extended to the offset width.
    idx_off = {field_i[5], field_i[5:0]};

    // Update mode: 5-bit signed step, where code zero stands for +16.
    if (field_i[4:0] == 5'd0) begin
      step_off = 7'sd16;
    end else begin
      step_off = {{2{field_i[4]}}, field_i[4:0]};
    end

    op_o.valid = is_ptr_i & field_i[8];
    op_o.sel   = op_o.valid & field_i[7];
    op_o.upd   = field_i[6];
    op_o.post  = field_i[6] & field_i[5];
    op_o.off   = field_i[6] ? step_off : idx_off;
  end

endmodule

// File: rtl/ptr_offset_scale.sv
module ptr_offset_scale
  import agu_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic signed [OFF_W-1:0] off_i,
  input  logic [1:0]              size_i,
  output logic [AW-1:0]           scaled_o
);

  logic [AW-1:0] ext;

  always_comb begin
    ext = {{(AW-OFF_W){off_i[OFF_W-1]}}, off_i};
    case (acc_size_e'(size_i))
      SZ_BYTE: scaled_o = ext;
      SZ_WORD: scaled_o = ext << 1;
      default: scaled_o = ext << 2;
    endcase
  end

endmodule

// File: rtl/ptr_bank.sv
module ptr_bank #(
  parameter int AW   = 20,
  parameter int NPTR = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wb_en_i,
  input  logic [$clog2(NPTR)-1:0]    wb_sel_i,
  input  logic [AW-1:0]              wb_val_i,
  input  logic                       ld_en_i,
  input  logic [$clog2(NPTR)-1:0]    ld_sel_i,
  input  logic [AW-1:0]              ld_val_i,
  output logic [NPTR-1:0][AW-1:0]    ptr_o
);

  localparam int SW = $clog2(NPTR);

  logic [NPTR-1:0][AW-1:0] ptr_q;
  logic [NPTR-1:0][AW-1:0] ptr_d;
  logic [NPTR-1:0]         ptr_en;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_comb begin
      ptr_en[g] = 1'b0;
      ptr_d[g]  = ptr_q[g];
      if (wb_en_i && (wb_sel_i == SW'(g))) begin
        ptr_en[g] = 1'b1;
        ptr_d[g]  = wb_val_i;
      end
      // The software load takes priority over the access writeback.
      if (ld_en_i && (ld_sel_i == SW'(g))) begin
        ptr_en[g] = 1'b1;
        ptr_d[g]  = ld_val_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[g] <= '0;
      end else if (ptr_en[g]) begin
        ptr_q[g] <= ptr_d[g];
      end
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
  import agu_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [8:0]         field_i,
  input  logic               is_ptr_i,
  input  logic [1:0]         size_i,
  input  logic               commit_i,
  input  logic [AW-1:0]      reg_val_i,
  input  logic               ld_en_i,
  input  logic               ld_sel_i,
  input  logic [AW-1:0]      ld_val_i,
  output logic [AW-1:0]      addr_o,
  output logic               sel_o,
  output logic [AW-1:0]      ptr_a_o,
  output logic [AW-1:0]      ptr_b_o
);

  localparam int NPTR = 2;

  ptr_op_t                 op;
  logic [AW-1:0]           scaled;
  logic [AW-1:0]           base;
  logic [AW-1:0]           sum;
  logic [NPTR-1:0][AW-1:0] ptrs;
  logic                    wb_en;

  ptr_field_decode u_dec (
    .field_i  (field_i),
    .is_ptr_i (is_ptr_i),
    .op_o     (op)
  );

  ptr_offset_scale #(.AW(AW)) u_scale (
    .off_i    (op.off),
    .size_i   (size_i),
    .scaled_o (scaled)
  );

  always_comb begin
    base  = ptrs[op.sel];
    sum   = base + scaled;
    wb_en = commit_i & op.valid & op.upd;
    if (!op.valid) begin
      addr_o = reg_val_i;
    end else if (op.post) begin
      addr_o = base;
    end else begin
      addr_o = sum;
    end
  end

  ptr_bank #(.AW(AW), .NPTR(NPTR)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wb_en_i  (wb_en),
    .wb_sel_i (op.sel),
    .wb_val_i (sum),
    .ld_en_i  (ld_en_i),
    .ld_sel_i (ld_sel_i),
    .ld_val_i (ld_val_i),
    .ptr_o    (ptrs)
  );

  assign sel_o   = op.sel;
  assign ptr_a_o = ptrs[0];
  assign ptr_b_o = ptrs[1];

endmodule

// File: rtl/ptr_agu_chk.sv
module ptr_agu_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic [8:0]    field_i,
  input logic          is_ptr_i,
  input logic          commit_i,
  input logic [AW-1:0] reg_val_i,
  input logic          ld_en_i,
  input logic          ld_sel_i,
  input logic [AW-1:0] ld_val_i,
  input logic [AW-1:0] addr_o,
  input logic          sel_o,
  input logic [AW-1:0] ptr_a_o,
  input logic [AW-1:0] ptr_b_o
);

  logic ptr_mode;
  assign ptr_mode = is_ptr_i & field_i[8];

  // R12: non-pointer operands pass reg_val_i through and select A.
  assert_passthru_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_mode |-> (addr_o == reg_val_i) && !sel_o);

  // R6: a post-update address is the selected pointer as it stands.
  assert_post_old_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_mode && field_i[6] && field_i[5]) |->
      (addr_o == (field_i[7] ? ptr_b_o : ptr_a_o)));

  // R5: a committed pre-update on A leaves A equal to the address it issued.
  assert_pre_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_mode && field_i[6] && !field_i[5] && !field_i[7] && commit_i && !ld_en_i)
      |=> (ptr_a_o == $past(addr_o)));

  // R3: a non-modifying access leaves both pointers alone.
  assert_no_modify_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_mode && !field_i[6] && !ld_en_i) |=> $stable(ptr_a_o) && $stable(ptr_b_o));

  // R10: with no commit and no load, the pointers hold.
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_i && !ld_en_i) |=> $stable(ptr_a_o) && $stable(ptr_b_o));

  // R11: a software load always lands, whatever the access does.
  assert_load_a_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en_i && !ld_sel_i) |=> (ptr_a_o == $past(ld_val_i)));
  assert_load_b_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en_i && ld_sel_i) |=> (ptr_b_o == $past(ld_val_i)));

endmodule

bind ptr_agu ptr_agu_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .field_i   (field_i),
  .is_ptr_i  (is_ptr_i),
  .commit_i  (commit_i),
  .reg_val_i (reg_val_i),
  .ld_en_i   (ld_en_i),
  .ld_sel_i  (ld_sel_i),
  .ld_val_i  (ld_val_i),
  .addr_o    (addr_o),
  .sel_o     (sel_o),
  .ptr_a_o   (ptr_a_o),
  .ptr_b_o   (ptr_b_o)
);

// File: tb/sim_ptr_agu.sv
`timescale 1ns/1ps
module sim_ptr_agu;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [8:0]  field_i;
  logic        is_ptr_i;
  logic [1:0]  size_i;
  logic        commit_i;
  logic [19:0] reg_val_i;
  logic        ld_en_i;
  logic        ld_sel_i;
  logic [19:0] ld_val_i;
  logic [19:0] addr_o;
  logic        sel_o;
  logic [19:0] ptr_a_o;
  logic [19:0] ptr_b_o;

  int checks   = 0;
  int failures = 0;
  logic [19:0] m_a;
  logic [19:0] m_b;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ptr_agu u0 (
    .clk(clk), .rst_n(rst_n), .field_i(field_i), .is_ptr_i(is_ptr_i),
    .size_i(size_i), .commit_i(commit_i), .reg_val_i(reg_val_i),
    .ld_en_i(ld_en_i), .ld_sel_i(ld_sel_i), .ld_val_i(ld_val_i),
    .addr_o(addr_o), .sel_o(sel_o), .ptr_a_o(ptr_a_o), .ptr_b_o(ptr_b_o)
  );

  task automatic check(string req, logic [19:0] act, logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  function automatic int mult(logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic int field_val(logic [8:0] f);
    if (!f[6]) return f[5] ? int'(f[5:0]) - 64 : int'(f[5:0]);
    if (f[4:0] == 5'd0) return 16;
    return f[4] ? int'(f[4:0]) - 32 : int'(f[4:0]);
  endfunction

  // One access cycle: drive, check the combinational outputs, clock, check the pointers.
  task automatic access(string req, logic [8:0] f, logic isp, logic [1:0] sz, logic cm,
                        logic [19:0] rv, logic le, logic ls, logic [19:0] lv);
    logic        pm;
    logic [19:0] base, sum, exp_addr;
    @(negedge clk);
    field_i = f; is_ptr_i = isp; size_i = sz; commit_i = cm;
    reg_val_i = rv; ld_en_i = le; ld_sel_i = ls; ld_val_i = lv;
    #1;
    pm   = isp & f[8];
    base = (pm && f[7]) ? m_b : m_a;
    sum  = base + 20'(field_val(f) * mult(sz));
    if (!pm)              exp_addr = rv;
    else if (f[6] && f[5]) exp_addr = base;
    else                  exp_addr = sum;
    check({req, " addr"}, addr_o, exp_addr);
    check({req, " sel R2"}, 20'(sel_o), 20'(pm & f[7]));
    @(posedge clk);
    #1;
    if (pm && f[6] && cm) begin
      if (f[7]) m_b = sum; else m_a = sum;
    end
    if (le) begin
      if (ls) m_b = lv; else m_a = lv;
    end
    check({req, " ptrA"}, ptr_a_o, m_a);
    check({req, " ptrB"}, ptr_b_o, m_b);
  endtask

  task automatic load(logic sel, logic [19:0] v);
    access("R11 load", 9'h000, 1'b0, 2'd0, 1'b0, 20'h0, 1'b1, sel, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    field_i = '0; is_ptr_i = 0; size_i = 0; commit_i = 0;
    reg_val_i = '0; ld_en_i = 0; ld_sel_i = 0; ld_val_i = '0;
    m_a = '0; m_b = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset A", ptr_a_o, 20'h0);
    check("R1 reset B", ptr_b_o, 20'h0);
    @(negedge clk);
    rst_n = 1'b1;

    load(1'b0, 20'h01000);
    load(1'b1, 20'h02000);
    // R3 index forms, with commit high to show no modification.
    access("R3 +1",  9'h101, 1, 2'd0, 1, 20'h0, 0, 0, 20'h0);
    access("R3 -1",  9'h13F, 1, 2'd0, 1, 20'h0, 0, 0, 20'h0);
    access("R3 -32", 9'h120, 1, 2'd0, 1, 20'h0, 0, 0, 20'h0);
    access("R3 plain A", 9'h100, 1, 2'd2, 1, 20'h0, 0, 0, 20'h0);
    access("R3 plain B", 9'h180, 1, 2'd2, 1, 20'h0, 0, 0, 20'h0);
    // R4 compatibility: -16 and +15 with bit5 = bit4.
    access("R4 -16", 9'h130, 1, 2'd1, 0, 20'h0, 0, 0, 20'h0);
    access("R4 +15", 9'h10F, 1, 2'd1, 0, 20'h0, 0, 0, 20'h0);
    // R5 / R6 / R7 update forms.
    access("R5 pre +1",   9'h141, 1, 2'd0, 1, 20'h0, 0, 0, 20'h0);
    access("R5 pre -1",   9'h15F, 1, 2'd0, 1, 20'h0, 0, 0, 20'h0);
    access("R5 pre -16",  9'h150, 1, 2'd0, 1, 20'h0, 0, 0, 20'h0);
    access("R6 post +1",  9'h161, 1, 2'd0, 1, 20'h0, 0, 0, 20'h0);
    access("R6 post -1",  9'h17F, 1, 2'd0, 1, 20'h0, 0, 0, 20'h0);
    access("R7 post +16", 9'h160, 1, 2'd0, 1, 20'h0, 0, 0, 20'h0);
    access("R6 B post -1",9'h1FF, 1, 2'd0, 1, 20'h0, 0, 0, 20'h0);
    // R8 sizes.
    access("R8 word",  9'h143, 1, 2'd1, 1, 20'h0, 0, 0, 20'h0);
    access("R8 long",  9'h1C3, 1, 2'd2, 1, 20'h0, 0, 0, 20'h0);
    access("R8 size3", 9'h163, 1, 2'd3, 1, 20'h0, 0, 0, 20'h0);
    // R9 wrap at both ends.
    load(1'b0, 20'h00004);
    access("R9 wrap down", 9'h150, 1, 2'd2, 1, 20'h0, 0, 0, 20'h0);
    load(1'b1, 20'hFFFF8);
    access("R9 wrap up", 9'h1C0, 1, 2'd2, 1, 20'h0, 0, 0, 20'h0);
    // R10 update field without commit.
    access("R10 no commit", 9'h141, 1, 2'd2, 0, 20'h0, 0, 0, 20'h0);
    // R11 collisions: same pointer, then the other pointer.
    access("R11 same", 9'h141, 1, 2'd0, 1, 20'h0, 1, 0, 20'h12345);
    access("R11 other", 9'h1C1, 1, 2'd0, 1, 20'h0, 1, 0, 20'h0ABCD);
    // R12 non-pointer, including a field with bit 8 set but flag low.
    access("R12 flag low", 9'h1C1, 0, 2'd2, 1, 20'hBEEF1, 0, 0, 20'h0);
    access("R12 bit8 low", 9'h0C1, 1, 2'd2, 1, 20'h54321, 0, 0, 20'h0);

    for (int i = 0; i < 3000; i++) begin
      logic [8:0] f;
      logic le;
      f  = 9'($urandom);
      le = ($urandom % 3) == 0;
      access("R2 rand", f, ($urandom % 5) != 0, 2'($urandom), 1'($urandom),
             20'($urandom), le, (($urandom % 4) != 0) ? f[7] : ~f[7], 20'($urandom));
    end

    // R1 again: asynchronous reset after activity.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset A again", ptr_a_o, 20'h0);
    check("R1 reset B again", ptr_b_o, 20'h0);
    m_a = '0; m_b = '0;
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule